// File: doc/BRIEF.md
# Plateau-Aware Peak Sawtooth Envelope

This block follows one real-valued projection of a two-channel signal and finds its local peaks, including peaks whose top is flat. Whenever a peak is found, it records two things. One is the value of a companion signal component at the same sample instant; the companion is either the real or the imaginary part of the input, and two instances run side by side to cover both. The other is how many samples have passed since the previous peak. Both records go into a pair of circular stores that are read in step with each other.

After a fixed start-up delay, the block emits one envelope sample for every accepted input sample. Each envelope sample lies on a straight line between two consecutive recorded peaks: it starts at the older peak value and reaches the newer one after the number of samples recorded for the newer peak. The block is meant as the per-projection envelope stage of a local-mean estimator. Averaging across projections is done outside it.

Both stream edges use valid/ready handshakes. An input sample is accepted when `s_valid_i` and `s_ready_o` are both high at a rising clock edge. `s_ready_o` is high whenever the output register is empty, or when it is being drained in the same cycle (`m_ready_i` high). The output beat stays valid and unchanged until it is taken. Because input and output move in lockstep, back-pressure on the output stalls the input directly. No sample is dropped or duplicated. The one status pin, `ovf_o`, is a plain sticky level.

Top module: `sawtooth_env`

## Requirements
- R1: While `rst_ni` is low, `m_valid_o` is 0, `ovf_o` is 0 and `s_ready_o` is 1.
- R2: Number the accepted projection samples p[n]. Sample n is a peak when (p[n] >= p[n+1] and p[n] > p[n-1]) or (p[n] > p[n+1] and p[n] >= p[n-1]). A flat top of two or more equal samples therefore yields peaks at its rising and falling ends, and a flat middle sample is never a peak. The comparison is signed 16-bit.
- R3: For each peak at sample n, the store receives the companion component c[n] (the same sample index) and the peak's gap. The gap is the number of accepted samples between this peak and the previous one. Entries are written at consecutive addresses.
- R4: The first envelope beat is produced by accepted sample index START_DLY (default 40, counting from 0). After that, exactly one envelope beat is produced per accepted sample, and none before.
- R5: The read pointer x starts at 1. The envelope value is V[x-1] + ((V[x] - V[x-1]) * k) / G[x], using signed division that truncates toward zero and is wrapped to 16 bits. Here k is the phase, V holds the stored values and G holds the stored gaps.
- R6: The phase k starts at 0 and rises by one on each envelope beat. On the beat where k equals G[x] - 1, k returns to 0 and x advances by one, modulo the store depth of 64.
- R7: A stored gap of 0 (an unwritten or cleared entry) is used as 1, so the output never depends on a division by zero.
- R8: When x advances, the entry at the old x-1 is cleared (value 0, gap 0). If a peak is written to that same entry in the same cycle, the write wins.
- R9: The block keeps a count of entries that have been written and not yet released. `ovf_o` goes high, and stays high until reset, when a peak is written while that count is already 64.
- R10: While `m_valid_o` is high and `m_ready_i` is low, `s_ready_o` is 0 and `m_env_o` holds its value. Every produced beat is delivered exactly once.
- R11: The gap saturates at 255. A gap of more than 255 samples is stored as 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_valid_i | input | 1 | Input sample valid |
| s_ready_o | output | 1 | Input sample accepted when high together with valid |
| s_proj_i | input | 16 | Signed projection sample |
| s_comp_i | input | 16 | Signed companion component sample |
| m_valid_o | output | 1 | Envelope beat valid |
| m_ready_i | input | 1 | Downstream accepts the envelope beat |
| m_env_o | output | 16 | Signed envelope sample |
| ovf_o | output | 1 | Sticky store-overflow flag |

## Verification
Two functions can land in the same cycle. A peak detection can write a store entry on the very cycle the read pointer advances and clears the entry behind it. Once the store is full, that write and that clear can also target the same entry. The first case is provoked by a lone early peak followed by a flat run. There the reader races past unwritten entries, and after wrapping the store it must return to the first entry and read it as cleared. The second case is provoked by holding the reader on one saturated-gap segment while peaks arrive every two samples. Both are judged beat by beat against envelope values and an overflow level computed independently in the bench from the requirements.

// File: rtl/sawenv_pkg.sv
package sawenv_pkg;

  // Output side: waiting for the start-up delay to expire, or streaming.
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_RUN  = 1'b1
  } run_ph_e;

endpackage

// File: rtl/sawenv_peak_det.sv
module sawenv_peak_det #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic signed [W-1:0] proj_i,
  input  logic signed [W-1:0] comp_i,
  output logic                hit_o,
  output logic signed [W-1:0] hit_val_o,
  output logic [CNT_W-1:0]    gap_o
);

  localparam int PSTAGES = 3;
  localparam int CSTAGES = 2;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic signed [W-1:0] p_sr [PSTAGES];
  logic signed [W-1:0] c_sr [CSTAGES];
  logic [1:0]          fill_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                full;
  logic signed [W-1:0] newer, mid, older;

  // Delay chains advance only on accepted samples; stage 0 holds the newest.
  for (genvar g = 0; g < PSTAGES; g++) begin : g_pchain
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     p_sr[g] <= '0;
        else if (step_i) p_sr[g] <= proj_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     p_sr[g] <= '0;
        else if (step_i) p_sr[g] <= p_sr[g-1];
      end
    end
  end

  for (genvar g = 0; g < CSTAGES; g++) begin : g_cchain
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     c_sr[g] <= '0;
        else if (step_i) c_sr[g] <= comp_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     c_sr[g] <= '0;
        else if (step_i) c_sr[g] <= c_sr[g-1];
      end
    end
  end

  assign newer = p_sr[0];
  assign mid   = p_sr[1];
  assign older = p_sr[2];
  assign full  = (fill_q == 2'd3);

  // A flat top is accepted from either side, never from its interior.
  assign hit_o     = full && (((mid >= newer) && (mid > older)) ||
                              ((mid > newer) && (mid >= older)));
  assign hit_val_o = c_sr[1];
  assign gap_o     = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      if (!full) fill_q <= fill_q + 1'b1;
      cnt_q <= hit_o ? '0 : gap_o;
    end
  end

  // R11: a saturated interval count stays pinned until a peak clears it.
  a_r11_cnt_pinned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q == CMAX) |=> (cnt_q == CMAX || cnt_q == '0))
    else $error("interval counter left saturation without a peak");

endmodule

// File: rtl/sawenv_max_store.sv
module sawenv_max_store #(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  parameter int DEPTH = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic signed [W-1:0] wr_val_i,
  input  logic [CNT_W-1:0]    wr_gap_i,
  input  logic                adv_i,
  output logic signed [W-1:0] a_prev_o,
  output logic signed [W-1:0] a_cur_o,
  output logic [CNT_W-1:0]    g_cur_o,
  output logic                ovf_o
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic signed [W-1:0] mem_v [DEPTH];
  logic [CNT_W-1:0]    mem_g [DEPTH];
  logic [AW-1:0]       wptr_q, rptr_q, pptr;
  logic [AW:0]         live_q;
  logic [AW+1:0]       live_sum;
  logic                rel;

  assign pptr     = rptr_q - AW'(1);
  assign a_prev_o = mem_v[pptr];
  assign a_cur_o  = mem_v[rptr_q];
  assign g_cur_o  = mem_g[rptr_q];

  assign rel      = adv_i && (live_q != '0);
  assign live_sum = (AW+2)'(live_q) + (AW+2)'(wr_en_i) - (AW+2)'(rel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        mem_v[k] <= '0;
        mem_g[k] <= '0;
      end
      wptr_q <= '0;
      rptr_q <= AW'(1);
      live_q <= '0;
      ovf_o  <= 1'b0;
    end else begin
      // Release first; a write to the same slot below takes precedence.
      if (adv_i) begin
        mem_v[pptr] <= '0;
        mem_g[pptr] <= '0;
        rptr_q      <= rptr_q + 1'b1;
      end
      if (wr_en_i) begin
        mem_v[wptr_q] <= wr_val_i;
        mem_g[wptr_q] <= wr_gap_i;
        wptr_q        <= wptr_q + 1'b1;
        if (live_q == FULL) ovf_o <= 1'b1;
      end
      live_q <= (live_sum > (AW+2)'(FULL)) ? FULL : live_sum[AW:0];
    end
  end

  // R9: once raised, the overflow level holds until reset.
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o)
    else $error("overflow flag dropped");

  // R8: a released slot reads back as empty unless a write claimed it.
  a_r8_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !(wr_en_i && wptr_q == pptr)) |=>
      (mem_v[$past(pptr)] == '0 && mem_g[$past(pptr)] == '0))
    else $error("released slot not cleared");

endmodule

// File: rtl/sawenv_interp.sv
module sawenv_interp #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] a_prev_i,
  input  logic signed [W-1:0] a_cur_i,
  input  logic [CNT_W-1:0]    g_cur_i,
  output logic signed [W-1:0] y_o,
  output logic                adv_o
);

  localparam int PW = W + CNT_W + 2;

  logic [CNT_W-1:0]     phase_q, len;
  logic signed [W:0]    diff;
  logic signed [PW-1:0] prod, den, quo;

  // An empty entry has gap 0; it is read as a one-sample segment.
  assign len  = (g_cur_i == '0) ? CNT_W'(1) : g_cur_i;
  assign diff = (W+1)'(a_cur_i) - (W+1)'(a_prev_i);
  assign prod = PW'(diff) * PW'($signed({1'b0, phase_q}));
  assign den  = PW'($signed({1'b0, len}));
  assign quo  = prod / den;
  assign y_o  = W'(PW'(a_prev_i) + quo);

  assign adv_o = en_i && (phase_q == len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (adv_o) phase_q <= '0;
    else if (en_i)  phase_q <= phase_q + 1'b1;
  end

  // R6: a segment always opens with phase zero.
  a_r6_segment_opens_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> (phase_q == '0))
    else $error("phase not restarted after advance");

endmodule

// File: rtl/sawtooth_env.sv
module sawtooth_env
  import sawenv_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int DEPTH     = 64,
  parameter int START_DLY = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_proj_i,
  input  logic [DATA_W-1:0] s_comp_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_env_o,
  output logic              ovf_o
);

  localparam int SCW = $clog2(START_DLY + 1);

  run_ph_e                  ph_q;
  logic [SCW-1:0]           st_q;
  logic                     step, run, hit, wr_en, adv;
  logic signed [DATA_W-1:0] hit_val, a_prev, a_cur, y;
  logic [CNT_W-1:0]         gap, g_cur;

  assign s_ready_o = !m_valid_o || m_ready_i;
  assign step      = s_valid_i && s_ready_o;
  assign run       = (ph_q == PH_RUN);
  assign wr_en     = step && hit;

  sawenv_peak_det #(.W(DATA_W), .CNT_W(CNT_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .proj_i    (s_proj_i),
    .comp_i    (s_comp_i),
    .hit_o     (hit),
    .hit_val_o (hit_val),
    .gap_o     (gap)
  );

  sawenv_max_store #(.W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_val_i (hit_val),
    .wr_gap_i (gap),
    .adv_i    (adv),
    .a_prev_o (a_prev),
    .a_cur_o  (a_cur),
    .g_cur_o  (g_cur),
    .ovf_o    (ovf_o)
  );

  sawenv_interp #(.W(DATA_W), .CNT_W(CNT_W)) u_interp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (step && run),
    .a_prev_i (a_prev),
    .a_cur_i  (a_cur),
    .g_cur_i  (g_cur),
    .y_o      (y),
    .adv_o    (adv)
  );

  // Start-up delay counted in accepted samples, not in clock cycles.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_WAIT;
      st_q <= '0;
    end else if (step && !run) begin
      st_q <= st_q + 1'b1;
      if (st_q == SCW'(START_DLY - 1)) ph_q <= PH_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_o <= 1'b0;
      m_env_o   <= '0;
    end else if (step && run) begin
      m_valid_o <= 1'b1;
      m_env_o   <= y;
    end else if (m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end

  // R10: a stalled beat neither vanishes nor changes.
  a_r10_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_env_o)))
    else $error("stalled envelope beat changed");

  // R4: nothing leaves the block before the start-up delay has run out.
  a_r4_quiet_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WAIT) |-> !m_valid_o)
    else $error("envelope beat before start-up delay");

endmodule

// File: tb/sawtooth_env_tb_top.sv
module sawtooth_env_tb_top;

  localparam int CLK_NS = 10;
  localparam int DEPTH  = 64;
  localparam int DLY    = 40;
  localparam int GMAX   = 255;
  localparam int PHMOD  = 256;

  logic               clk, rst_n;
  logic               s_valid, s_ready, m_valid, m_ready, ovf;
  logic [15:0]        s_proj, s_comp;
  logic signed [15:0] m_env;

  sawtooth_env dut_i (
    .clk_i(clk), .rst_ni(rst_n), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .s_proj_i(s_proj), .s_comp_i(s_comp), .m_valid_o(m_valid),
    .m_ready_i(m_ready), .m_env_o(m_env), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // Independent model built from the requirements.
  int hp [3];
  int hc [2];
  int m_fill, m_cnt, m_start, m_w, m_r, m_ph, m_live, m_steps, first_out;
  bit m_run, m_ovf;
  int ma [DEPTH];
  int mg [DEPTH];
  int expq [$];
  bit held;
  int held_val;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) hp[k] = 0;
    for (int k = 0; k < 2; k++) hc[k] = 0;
    for (int k = 0; k < DEPTH; k++) begin ma[k] = 0; mg[k] = 0; end
    m_fill = 0; m_cnt = 0; m_start = 0; m_w = 0; m_r = 1; m_ph = 0;
    m_live = 0; m_steps = 0; first_out = -1; m_run = 0; m_ovf = 0;
    held = 0; held_val = 0;
    expq.delete();
  endtask

  task automatic model_step(input int pv, input int cv);
    bit hit, adv, rel;
    int gap, len, ap, ac, pidx;
    adv = 0;
    pidx = (m_r + DEPTH - 1) % DEPTH;
    hit = (m_fill == 3) && (((hp[1] >= hp[0]) && (hp[1] > hp[2])) ||
                            ((hp[1] > hp[0]) && (hp[1] >= hp[2])));
    gap = (m_cnt >= GMAX) ? GMAX : m_cnt + 1;
    if (m_run) begin
      ap = ma[pidx];
      ac = ma[m_r];
      len = (mg[m_r] == 0) ? 1 : mg[m_r];
      expq.push_back(sx16(ap + ((ac - ap) * m_ph) / len));
      if (first_out < 0) first_out = m_steps;
      if (m_ph == len - 1) begin adv = 1; m_ph = 0; end
      else m_ph = (m_ph + 1) % PHMOD;
    end
    rel = adv && (m_live > 0);
    if (adv) begin ma[pidx] = 0; mg[pidx] = 0; m_r = (m_r + 1) % DEPTH; end
    if (hit) begin
      if (m_live == DEPTH) m_ovf = 1;
      ma[m_w] = hc[1]; mg[m_w] = gap; m_w = (m_w + 1) % DEPTH;
    end
    m_live = m_live + (hit ? 1 : 0) - (rel ? 1 : 0);
    if (m_live > DEPTH) m_live = DEPTH;
    m_cnt = hit ? 0 : gap;
    if (m_fill < 3) m_fill++;
    hp[2] = hp[1]; hp[1] = hp[0]; hp[0] = sx16(pv);
    hc[1] = hc[0]; hc[0] = sx16(cv);
    if (!m_run) begin
      if (m_start == DLY - 1) m_run = 1;
      m_start++;
    end
    m_steps++;
  endtask

  // One clock of stimulus; called just after a falling edge.
  task automatic beat(input int pv, input int cv, input bit vld, input bit rdy,
                      input string req);
    bit acc, pop;
    check(m_valid == (expq.size() > 0), "R4 valid", int'(m_valid),
          (expq.size() > 0) ? 1 : 0);
    if (held && m_valid) check(int'(m_env) == held_val, "R10 hold", int'(m_env), held_val);
    s_proj = pv[15:0]; s_comp = cv[15:0]; s_valid = vld; m_ready = rdy;
    #1;
    acc = vld && (!m_valid || rdy);
    pop = m_valid && rdy;
    held = m_valid && !rdy;
    held_val = int'(m_env);
    if (held) check(s_ready == 1'b0, "R10 ready", int'(s_ready), 0);
    if (pop) begin
      check(int'(m_env) == expq[0], req, int'(m_env), expq[0]);
      void'(expq.pop_front());
    end
    if (acc) model_step(pv, cv);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b1; s_proj = '0; s_comp = '0;
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R1 valid", int'(m_valid), 0);
    check(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
    check(s_ready == 1'b1, "R1 ready", int'(s_ready), 1);
    model_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int tri12(input int n);
    case (n % 12)
      0: return 0;   1: return 4;   2: return 8;   3: return 12;
      4: return 12;  5: return 12;  6: return 8;   7: return 4;
      8: return 0;   9: return 2;   10: return 5;  default: return 2;
    endcase
  endfunction

  function automatic int flat10(input int n);
    case (n % 10)
      0: return 0;  1: return 6;  2: return 6;  3: return 6;  4: return 6;
      5: return 2;  6: return 1;  7: return 7;  8: return 7;  default: return 0;
    endcase
  endfunction

  task automatic t_shape();   // R5: mixed peaks with offsets
    do_reset();
    for (int n = 0; n < 240; n++)
      beat(tri12(n) + (n / 12) * 3, ((n * 37) % 201) - 100, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_plateau(); // R2: only flat-topped peaks
    do_reset();
    for (int n = 0; n < 200; n++)
      beat(flat10(n), ((n * 11) % 300) - 150, 1'b1, 1'b1, "R2");
  endtask

  task automatic t_align();   // R3: companion captured at the peak sample
    do_reset();
    for (int n = 0; n < 200; n++)
      beat(tri12(n), ((n * 250) % 60000) - 30000, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_gaps();    // R6: segment lengths vary
    int len;
    do_reset();
    for (int n = 0; n < 300; n++) begin
      len = 3 + ((n / 30) % 5) * 4;
      beat(n % len, 500 - ((n * 13) % 1000), 1'b1, 1'b1, "R6");
    end
  endtask

  task automatic t_start();   // R4
    do_reset();
    for (int n = 0; n < 45; n++)
      beat(tri12(n), n, 1'b1, 1'b1, "R4");
    check(first_out == DLY, "R4 first beat index", first_out, DLY);
  endtask

  task automatic t_clear();   // R7, R8
    do_reset();
    for (int n = 0; n < 112; n++)
      beat((n == 1) ? 5 : 0, (n == 1) ? 100 : 7, 1'b1, 1'b1,
           (n < 100) ? "R7" : "R8");
  endtask

  task automatic t_sat();     // R11
    do_reset();
    for (int n = 0; n < 700; n++)
      beat((n == 1) ? 5 : ((n == 400) ? 9 : 0), (n == 1) ? 50 : ((n == 400) ? -200 : 3),
           1'b1, 1'b1, "R11");
  endtask

  task automatic t_ovf();     // R9
    int pv;
    do_reset();
    for (int n = 0; n < 650; n++) begin
      if (n == 430) check(ovf == m_ovf && ovf == 1'b0, "R9 before burst", int'(ovf), 0);
      if (n >= 430) pv = n % 2;
      else pv = (n == 1) ? 5 : ((n == 400) ? 9 : 0);
      beat(pv, 1 + (n % 3), 1'b1, 1'b1, "R9");
    end
    check(ovf == 1'b1, "R9 raised", int'(ovf), 1);
    check(m_ovf == 1'b1, "R9 model agrees", int'(m_ovf), 1);
  endtask

  task automatic t_backpr();  // R10
    do_reset();
    for (int n = 0; n < 200; n++)
      beat(tri12(n) * 7, ((n * 53) % 400) - 200, (n % 5) != 4, (n % 3) != 0, "R10");
    for (int n = 0; n < 3; n++) beat(0, 0, 1'b0, 1'b1, "R10");
    check(expq.size() == 0, "R10 all delivered", expq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b1; s_proj = '0; s_comp = '0;
    model_reset();
    t_shape();
    t_plateau();
    t_align();
    t_gaps();
    t_start();
    t_clear();
    t_sat();
    t_ovf();
    t_backpr();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule